// File: doc/BRIEF.md
# Power-Managed Light and Proximity Measurement Sequencer

This block schedules the measurements of a combined ambient-light and proximity sensor. It stays asleep until a power enable is raised, lets one base step pass so the analog front end can settle, and then runs a repeating cycle. Each cycle has up to three phases in a fixed order: a proximity phase, a wait phase and an ambient-light phase. Each phase runs only when its own enable is set. All phase lengths are counted in base steps, and the step tick comes from outside the block. The proximity phase drives an LED pulse train and then a conversion. The ambient-light phase converts two channels at once.

The converters themselves are not part of this block. Each converter is modelled as a stub. It receives a start strobe and a latch strobe. It then returns its result over a valid/ready handshake: the stub raises valid with its data and holds both stable until ready is seen high at a clock edge. The sequencer raises ready only while it waits for that result, and it stalls in that state for as long as the stub withholds valid. A valid that arrives while ready is low is ignored.

Results are kept in output registers with sticky valid flags. When the power enable is cleared, the block does not stop at once. It completes the cycle already under way and only then drops back to sleep.

Top module: `lightprox_seq`

## Requirements
- R1: After reset, and for as long as `pon` stays low, the block is asleep. While asleep, `asleep`=1, `led_on`=0, no strobe or ready output is raised, and both valid flags read 0.
- R2: When `pon` rises in sleep, exactly one step tick elapses in a settle period before the first proximity or ambient-light phase starts. Both valid flags are cleared during that settle period.
- R3: A cycle runs the proximity phase, then the wait phase, then the ambient-light phase, skipping each phase whose enable is 0. The enables are sampled only in the start state between cycles, so a change made mid-cycle takes effect on the next pass.
- R4: The proximity phase begins with a one-cycle `prox_start` strobe. It then emits N LED pulses, where N is `pulse_count`, or 1 when `pulse_count`=0. Each pulse holds `led_on` high for PULSE_HALF_CLKS clocks and then low for the same number of clocks.
- R5: The proximity conversion, the wait and the ambient-light conversion each last 256−v steps, where v is the 8-bit time value (0xFF gives 1 step, 0x00 gives 256). With `wait_long`=1, each wait step takes 12 step ticks.
- R6: The ambient-light phase raises `als_start`. After its steps it raises `als_latch`. Both channel values are then accepted in a single handshake and update `als_ch0` and `als_ch1` together, and `als_valid` is set.
- R7: At the end of the proximity conversion the block raises `prox_latch`. The result taken by the handshake appears on `prox_data`, and `prox_valid` is set.
- R8: A result is taken only at an edge where both valid and ready are high. `prox_ready` and `als_ready` are never high together. Output data holds its value at every other edge.
- R9: Clearing `pon` does not abort a cycle. The phases already begun are completed, including their result transfers, and the block then returns to sleep.
- R10: With `pon`=1 and all three enables at 0, the block stays in the start state. It is not asleep, it issues no strobe and it pulses no LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_tick | input | 1 | One-cycle base step tick |
| pon | input | 1 | Power enable |
| prox_en | input | 1 | Proximity phase enable |
| wait_en | input | 1 | Wait phase enable |
| als_en | input | 1 | Ambient-light phase enable |
| wait_long | input | 1 | Stretch each wait step to 12 ticks |
| prox_time | input | 8 | Proximity conversion time value (256−v steps) |
| wait_time | input | 8 | Wait time value (256−v steps) |
| als_time | input | 8 | Ambient-light time value (256−v steps) |
| pulse_count | input | 8 | LED pulses per proximity phase (0 gives 1) |
| prox_res_valid | input | 1 | Proximity result valid from converter stub |
| prox_res_data | input | PROX_W | Proximity result data |
| als_res_valid | input | 1 | Ambient-light result valid from converter stub |
| als_res_ch0 | input | ALS_W | Visible-plus-IR channel result |
| als_res_ch1 | input | ALS_W | IR channel result |
| asleep | output | 1 | Sequencer is in sleep |
| led_on | output | 1 | LED drive pulse |
| prox_start | output | 1 | Proximity integration start strobe |
| prox_latch | output | 1 | Proximity conversion latch strobe |
| prox_ready | output | 1 | Ready for proximity result |
| als_start | output | 1 | Ambient-light integration start strobe |
| als_latch | output | 1 | Ambient-light conversion latch strobe |
| als_ready | output | 1 | Ready for ambient-light result |
| prox_data | output | PROX_W | Last accepted proximity result |
| prox_valid | output | 1 | Proximity result present since wake |
| als_ch0 | output | ALS_W | Last accepted channel 0 result |
| als_ch1 | output | ALS_W | Last accepted channel 1 result |
| als_valid | output | 1 | Ambient-light result present since wake |

## Verification
The hardest situation to reach from the ports is a drop of `pon` while a conversion is actually in flight. From outside, the block has to be caught between `als_start` and the result transfer. The stimulus therefore watches for the `als_start` strobe, clears `pon` right after it, and then expects one more result transfer before `asleep` returns. Exact step counts are the second difficulty, because the step tick runs free against phase entry. The bench counts ticks between strobe and handshake events with the register latency of each phase subtracted, so any off-by-one in a timer or in the 12x stretch shows up as a count mismatch.

// File: rtl/lightprox_seq_pkg.sv
package lightprox_seq_pkg;

  typedef enum logic [3:0] {
    ST_SLEEP,
    ST_SETTLE,
    ST_START,
    ST_PULSE,
    ST_PCONV,
    ST_PRES,
    ST_WAIT,
    ST_ACONV,
    ST_ARES
  } seq_state_e;

  localparam int TIME_W  = 8;
  localparam int STEPS_W = TIME_W + 1;

  // Two's-complement style time value: 256 - v steps.
  function automatic logic [STEPS_W-1:0] steps_of(input logic [TIME_W-1:0] v);
    return STEPS_W'(1 << TIME_W) - {1'b0, v};
  endfunction

endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int CW        = 9,
  parameter int LONG_MULT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] steps,
  input  logic          long_mode,
  input  logic          step_tick,
  output logic          done
);
  localparam int PW = (LONG_MULT > 1) ? $clog2(LONG_MULT) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(LONG_MULT - 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        cnt_q  <= steps;
        pre_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && step_tick) begin
        if (long_mode && (pre_q != PRE_LAST)) begin
          pre_q <= pre_q + 1'b1;
        end else begin
          pre_q <= '0;
          if (cnt_q <= CW'(1)) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen #(
  parameter int HALF_CLKS = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             led,
  output logic             done
);
  localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [HW-1:0] PH_LAST = HW'(HALF_CLKS - 1);

  logic [HW-1:0]    ph_q;
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             led_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      led_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= (count == '0) ? CNT_W'(1) : count;
        ph_q   <= '0;
        led_q  <= 1'b1;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (ph_q == PH_LAST) begin
          ph_q <= '0;
          if (led_q) begin
            led_q <= 1'b0;
          end else if (rem_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            rem_q <= rem_q - 1'b1;
            led_q <= 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign led  = led_q;
  assign done = done_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import lightprox_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pon,
  input  logic               prox_en,
  input  logic               wait_en,
  input  logic               als_en,
  input  logic               wait_long,
  input  logic [TIME_W-1:0]  prox_time,
  input  logic [TIME_W-1:0]  wait_time,
  input  logic [TIME_W-1:0]  als_time,
  input  logic               tmr_done,
  input  logic               pg_done,
  input  logic               prox_hs,
  input  logic               als_hs,
  output seq_state_e         state,
  output logic               tmr_load,
  output logic [STEPS_W-1:0] tmr_steps,
  output logic               tmr_long,
  output logic               pg_start,
  output logic               prox_latch,
  output logic               als_start,
  output logic               als_latch
);
  seq_state_e state_q, nxt;
  logic en_prox_q, en_wait_q, en_als_q;
  logic entering, timed_nxt;
  logic [STEPS_W-1:0] steps_nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_SLEEP:  if (pon) nxt = ST_SETTLE;
      ST_SETTLE: if (tmr_done) nxt = ST_START;
      ST_START: begin
        if (!pon)         nxt = ST_SLEEP;
        else if (prox_en) nxt = ST_PULSE;
        else if (wait_en) nxt = ST_WAIT;
        else if (als_en)  nxt = ST_ACONV;
      end
      ST_PULSE:  if (pg_done) nxt = ST_PCONV;
      ST_PCONV:  if (tmr_done) nxt = ST_PRES;
      ST_PRES: begin
        if (prox_hs) begin
          if (en_wait_q)     nxt = ST_WAIT;
          else if (en_als_q) nxt = ST_ACONV;
          else               nxt = ST_START;
        end
      end
      ST_WAIT:   if (tmr_done) nxt = en_als_q ? ST_ACONV : ST_START;
      ST_ACONV:  if (tmr_done) nxt = ST_ARES;
      ST_ARES:   if (als_hs) nxt = ST_START;
      default:   nxt = ST_SLEEP;
    endcase
  end

  assign entering  = (nxt != state_q);
  assign timed_nxt = (nxt == ST_SETTLE) || (nxt == ST_PCONV) ||
                     (nxt == ST_WAIT)   || (nxt == ST_ACONV);

  always_comb begin
    unique case (nxt)
      ST_PCONV: steps_nxt = steps_of(prox_time);
      ST_WAIT:  steps_nxt = steps_of(wait_time);
      ST_ACONV: steps_nxt = steps_of(als_time);
      default:  steps_nxt = STEPS_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_SLEEP;
      en_prox_q  <= 1'b0;
      en_wait_q  <= 1'b0;
      en_als_q   <= 1'b0;
      tmr_load   <= 1'b0;
      tmr_steps  <= '0;
      tmr_long   <= 1'b0;
      pg_start   <= 1'b0;
      prox_latch <= 1'b0;
      als_start  <= 1'b0;
      als_latch  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_START) begin
        en_prox_q <= prox_en;
        en_wait_q <= wait_en;
        en_als_q  <= als_en;
      end
      tmr_load <= entering && timed_nxt;
      if (entering && timed_nxt) begin
        tmr_steps <= steps_nxt;
        tmr_long  <= (nxt == ST_WAIT) && wait_long;
      end
      pg_start   <= entering && (nxt == ST_PULSE);
      prox_latch <= (state_q == ST_PCONV) && (nxt == ST_PRES);
      als_start  <= entering && (nxt == ST_ACONV);
      als_latch  <= (state_q == ST_ACONV) && (nxt == ST_ARES);
    end
  end

  assign state = state_q;
endmodule

// File: rtl/lightprox_seq.sv
module lightprox_seq
  import lightprox_seq_pkg::*;
#(
  parameter int PROX_W          = 10,
  parameter int ALS_W           = 16,
  parameter int PULSE_HALF_CLKS = 4,
  parameter int LONG_MULT       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic              pon,
  input  logic              prox_en,
  input  logic              wait_en,
  input  logic              als_en,
  input  logic              wait_long,
  input  logic [7:0]        prox_time,
  input  logic [7:0]        wait_time,
  input  logic [7:0]        als_time,
  input  logic [7:0]        pulse_count,
  input  logic              prox_res_valid,
  input  logic [PROX_W-1:0] prox_res_data,
  input  logic              als_res_valid,
  input  logic [ALS_W-1:0]  als_res_ch0,
  input  logic [ALS_W-1:0]  als_res_ch1,
  output logic              asleep,
  output logic              led_on,
  output logic              prox_start,
  output logic              prox_latch,
  output logic              prox_ready,
  output logic              als_start,
  output logic              als_latch,
  output logic              als_ready,
  output logic [PROX_W-1:0] prox_data,
  output logic              prox_valid,
  output logic [ALS_W-1:0]  als_ch0,
  output logic [ALS_W-1:0]  als_ch1,
  output logic              als_valid
);
  seq_state_e         state;
  logic               tmr_load, tmr_long, tmr_done;
  logic [STEPS_W-1:0] tmr_steps;
  logic               pg_start, pg_done;
  logic               prox_hs, als_hs;

  assign prox_ready = (state == ST_PRES);
  assign als_ready  = (state == ST_ARES);
  assign asleep     = (state == ST_SLEEP);
  assign prox_hs    = prox_res_valid && prox_ready;
  assign als_hs     = als_res_valid && als_ready;
  assign prox_start = pg_start;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pon        (pon),
    .prox_en    (prox_en),
    .wait_en    (wait_en),
    .als_en     (als_en),
    .wait_long  (wait_long),
    .prox_time  (prox_time),
    .wait_time  (wait_time),
    .als_time   (als_time),
    .tmr_done   (tmr_done),
    .pg_done    (pg_done),
    .prox_hs    (prox_hs),
    .als_hs     (als_hs),
    .state      (state),
    .tmr_load   (tmr_load),
    .tmr_steps  (tmr_steps),
    .tmr_long   (tmr_long),
    .pg_start   (pg_start),
    .prox_latch (prox_latch),
    .als_start  (als_start),
    .als_latch  (als_latch)
  );

  seq_step_timer #(.CW(STEPS_W), .LONG_MULT(LONG_MULT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .steps     (tmr_steps),
    .long_mode (tmr_long),
    .step_tick (step_tick),
    .done      (tmr_done)
  );

  seq_pulse_gen #(.HALF_CLKS(PULSE_HALF_CLKS), .CNT_W(8)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pg_start),
    .count (pulse_count),
    .led   (led_on),
    .done  (pg_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prox_data  <= '0;
      prox_valid <= 1'b0;
      als_ch0    <= '0;
      als_ch1    <= '0;
      als_valid  <= 1'b0;
    end else begin
      if (state == ST_SETTLE) begin
        prox_valid <= 1'b0;
        als_valid  <= 1'b0;
      end
      if (prox_hs) begin
        prox_data  <= prox_res_data;
        prox_valid <= 1'b1;
      end
      if (als_hs) begin
        als_ch0   <= als_res_ch0;
        als_ch1   <= als_res_ch1;
        als_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lightprox_seq_chk.sv
module lightprox_seq_chk #(
  parameter int PROX_W = 10,
  parameter int ALS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pon,
  input logic              asleep,
  input logic              led_on,
  input logic              prox_start,
  input logic              prox_latch,
  input logic              prox_ready,
  input logic              als_start,
  input logic              als_latch,
  input logic              als_ready,
  input logic              prox_res_valid,
  input logic              als_res_valid,
  input logic [PROX_W-1:0] prox_data,
  input logic              prox_valid,
  input logic [ALS_W-1:0]  als_ch0,
  input logic [ALS_W-1:0]  als_ch1,
  input logic              als_valid
);
  a_r1_quiet_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!led_on && !prox_start && !als_start && !prox_ready && !als_ready));

  a_r3_strobes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prox_start, prox_latch, als_start, als_latch}));

  a_r4_led_outside_results: assert property (@(posedge clk) disable iff (!rst_n)
    led_on |-> (!prox_ready && !als_ready && !als_start));

  a_r8_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(prox_ready && als_ready));

  a_r8_prox_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(prox_res_valid && prox_ready) |=> $stable(prox_data));

  a_r6_als_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(als_res_valid && als_ready) |=> ($stable(als_ch0) && $stable(als_ch1)));

  a_r7_pvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prox_valid) |-> $past(prox_res_valid && prox_ready));

  a_r6_avalid_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(als_valid) |-> $past(als_res_valid && als_ready));

  a_r9_sleep_needs_pon_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> !$past(pon));
endmodule

bind lightprox_seq lightprox_seq_chk #(.PROX_W(PROX_W), .ALS_W(ALS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pon            (pon),
  .asleep         (asleep),
  .led_on         (led_on),
  .prox_start     (prox_start),
  .prox_latch     (prox_latch),
  .prox_ready     (prox_ready),
  .als_start      (als_start),
  .als_latch      (als_latch),
  .als_ready      (als_ready),
  .prox_res_valid (prox_res_valid),
  .als_res_valid  (als_res_valid),
  .prox_data      (prox_data),
  .prox_valid     (prox_valid),
  .als_ch0        (als_ch0),
  .als_ch1        (als_ch1),
  .als_valid      (als_valid)
);

// File: tb/sim_lightprox_seq.sv
`timescale 1ns/1ps
module sim_lightprox_seq;
  localparam int PROX_W = 10;
  localparam int ALS_W  = 16;
  localparam int HALF   = 4;
  localparam int TP     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_tick = 1'b0;
  logic pon = 1'b0, prox_en = 1'b0, wait_en = 1'b0, als_en = 1'b0, wait_long = 1'b0;
  logic [7:0] prox_time = 8'hFF, wait_time = 8'hFF, als_time = 8'hFF, pulse_count = 8'd1;
  logic prox_res_valid = 1'b0, als_res_valid = 1'b0;
  logic [PROX_W-1:0] prox_res_data = '0;
  logic [ALS_W-1:0]  als_res_ch0 = '0, als_res_ch1 = '0;
  logic asleep, led_on, prox_start, prox_latch, prox_ready, als_start, als_latch, als_ready;
  logic [PROX_W-1:0] prox_data;
  logic prox_valid, als_valid;
  logic [ALS_W-1:0] als_ch0, als_ch1;

  always #4 clk = ~clk;

  lightprox_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .pon(pon),
    .prox_en(prox_en), .wait_en(wait_en), .als_en(als_en), .wait_long(wait_long),
    .prox_time(prox_time), .wait_time(wait_time), .als_time(als_time),
    .pulse_count(pulse_count),
    .prox_res_valid(prox_res_valid), .prox_res_data(prox_res_data),
    .als_res_valid(als_res_valid), .als_res_ch0(als_res_ch0), .als_res_ch1(als_res_ch1),
    .asleep(asleep), .led_on(led_on), .prox_start(prox_start), .prox_latch(prox_latch),
    .prox_ready(prox_ready), .als_start(als_start), .als_latch(als_latch),
    .als_ready(als_ready), .prox_data(prox_data), .prox_valid(prox_valid),
    .als_ch0(als_ch0), .als_ch1(als_ch1), .als_valid(als_valid)
  );

  int chk_n = 0, err_n = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    chk_n++;
    if (!ok) begin
      err_n++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int steps_of(input logic [7:0] v);
    return 256 - int'(v);
  endfunction

  function automatic int pulses_of(input logic [7:0] c);
    return (c == 8'd0) ? 1 : int'(c);
  endfunction

  // monitor state
  bit mon_on = 0;
  int tc = 0;
  int t_prev = 0;
  bit prev_led = 0, prev_asleep = 1;
  bit sw_on = 0; int sw_ph = 0, sw_tot = 0;
  bit aw_on = 0; int aw_ph = 0, aw_tot = 0, a_exp = 0;
  bit ww_on = 0; int ww_ph = 0, ww_tot = 0;
  bit p_on = 0; int pulses = 0, p_exp = 0, led_run = 0;
  bit pd_arm = 0, ad_arm = 0; int pd_wait = 0, ad_wait = 0;
  bit p_pend = 0, a_pend = 0;
  logic [PROX_W-1:0] p_expd;
  logic [ALS_W-1:0] a_exp0, a_exp1;
  int prox_hs_cnt = 0, als_hs_cnt = 0, als_start_cnt = 0, strobe_cnt = 0;
  bit junk_req = 0, junk_drop = 0;

  always @(negedge clk) begin
    int t_now;
    t_now = int'(step_tick);
    if (mon_on) begin
      strobe_cnt += int'(prox_start) + int'(als_start) + int'(prox_latch) +
                    int'(als_latch) + int'(led_on);
      if (als_start) als_start_cnt++;
      // settle window (R2)
      if (sw_on) begin sw_ph++; if (sw_ph >= 2) sw_tot += t_now; end
      if (prev_asleep && !asleep && (prox_en || (als_en && !wait_en))) begin
        sw_on = 1; sw_ph = 0; sw_tot = 0;
      end
      if (sw_on && (prox_start || als_start)) begin
        check(sw_tot - t_now - t_prev == 1, "R2 settle ticks", sw_tot - t_now - t_prev, 1);
        check(!prox_valid && !als_valid, "R2 valid cleared on wake",
              int'(prox_valid) + int'(als_valid), 0);
        sw_on = 0;
      end
      // LED pulses (R4)
      if (led_on) led_run++;
      if (prev_led && !led_on) begin
        check(led_run == HALF, "R4 led on width", led_run, HALF);
        led_run = 0;
      end
      if (p_on && led_on && !prev_led) pulses++;
      if (p_on && prox_latch) begin
        check(pulses == p_exp, "R4 pulse count", pulses, p_exp);
        p_on = 0;
      end
      if (prox_start) begin p_on = 1; pulses = 0; p_exp = pulses_of(pulse_count); end
      // ALS step window (R5)
      if (aw_on) begin aw_ph++; if (aw_ph >= 2) aw_tot += t_now; end
      if (aw_on && als_latch) begin
        check(aw_tot - t_now == a_exp, "R5 ALS steps", aw_tot - t_now, a_exp);
        aw_on = 0;
      end
      // wait window (R5)
      if (ww_on) begin ww_ph++; if (ww_ph >= 2) ww_tot += t_now; end
      if (ww_on && als_start) begin
        check(ww_tot - t_now == steps_of(wait_time) * (wait_long ? 12 : 1),
              "R5 wait ticks", ww_tot - t_now, steps_of(wait_time) * (wait_long ? 12 : 1));
        ww_on = 0;
      end
      if (als_start) begin aw_on = 1; aw_ph = 0; aw_tot = 0; a_exp = steps_of(als_time); end
      if (asleep) begin aw_on = 0; ww_on = 0; p_on = 0; end
      // result checks after handshake edge (R6, R7)
      if (p_pend) begin
        check(prox_data == p_expd && prox_valid, "R7 prox result", prox_data, p_expd);
        prox_res_valid = 0; p_pend = 0;
      end
      if (a_pend) begin
        check(als_ch0 == a_exp0 && als_ch1 == a_exp1 && als_valid, "R6 ALS pair",
              {als_ch1, als_ch0}, {a_exp1, a_exp0});
        als_res_valid = 0; a_pend = 0;
      end
      if (junk_drop) begin prox_res_valid = 0; junk_drop = 0; end
      if (prox_res_valid && prox_ready) begin
        p_pend = 1; p_expd = prox_res_data; prox_hs_cnt++;
        if (wait_en && als_en) begin ww_on = 1; ww_ph = -1; ww_tot = 0; end
      end
      if (als_res_valid && als_ready) begin
        a_pend = 1; a_exp0 = als_res_ch0; a_exp1 = als_res_ch1; als_hs_cnt++;
        if (pon && wait_en && als_en && !prox_en) begin ww_on = 1; ww_ph = -2; ww_tot = 0; end
      end
      // converter stubs with back-pressure delay
      if (prox_latch) begin pd_arm = 1; pd_wait = $urandom_range(0, 3); end
      else if (pd_arm) begin
        if (pd_wait == 0) begin
          prox_res_valid = 1; prox_res_data = PROX_W'($urandom); pd_arm = 0;
        end else pd_wait--;
      end
      if (als_latch) begin ad_arm = 1; ad_wait = $urandom_range(0, 3); end
      else if (ad_arm) begin
        if (ad_wait == 0) begin
          als_res_valid = 1; als_res_ch0 = ALS_W'($urandom); als_res_ch1 = ALS_W'($urandom);
          ad_arm = 0;
        end else ad_wait--;
      end
      if (junk_req) begin
        prox_res_valid = 1; prox_res_data = 10'h2A5; junk_req = 0; junk_drop = 1;
      end
      prev_led = led_on;
      prev_asleep = asleep;
    end
    t_prev = t_now;
    tc = (tc + 1) % TP;
    step_tick = (tc == 0);
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    pon = 0;
    while (!asleep) @(negedge clk);
    wait_neg(2);
  endtask

  task automatic wait_als(input int n);
    int tgt;
    tgt = als_hs_cnt + n;
    while (als_hs_cnt < tgt) @(negedge clk);
  endtask

  task automatic wait_prox(input int n);
    int tgt;
    tgt = prox_hs_cnt + n;
    while (prox_hs_cnt < tgt) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", chk_n, err_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err_n++;
    $display("FAIL watchdog R9: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int seed, s0, s1, tot;
    seed = $urandom(32'h5EED);
    wait_neg(5);
    rst_n = 1;
    mon_on = 1;
    wait_neg(2);
    // R1 reset state
    check(asleep == 1, "R1 asleep after reset", asleep, 1);
    check(!led_on && !prox_valid && !als_valid, "R1 quiet after reset",
          int'(led_on) + int'(prox_valid) + int'(als_valid), 0);
    // R8 valid without ready ignored
    junk_req = 1;
    wait_neg(4);
    check(prox_data == '0 && !prox_valid, "R8 unready valid ignored", prox_data, 0);
    s0 = strobe_cnt;
    wait_neg(30);
    check(asleep && strobe_cnt == s0, "R1 stays asleep with pon low", strobe_cnt - s0, 0);

    // Directed: full cycle, short wait
    prox_en = 1; wait_en = 1; als_en = 1; wait_long = 0;
    pulse_count = 3; prox_time = 8'hFE; wait_time = 8'hFD; als_time = 8'hFC;
    pon = 1;
    wait_als(2);
    check(prox_valid && als_valid, "R3 both phases ran", int'(prox_valid) + int'(als_valid), 2);

    // Directed: long wait, no proximity
    go_sleep();
    prox_en = 0; wait_en = 1; als_en = 1; wait_long = 1;
    wait_time = 8'hFE; als_time = 8'hFF;
    s0 = prox_hs_cnt;
    pon = 1;
    wait_als(3);
    check(prox_hs_cnt == s0, "R3 disabled proximity skipped", prox_hs_cnt - s0, 0);

    // Directed: pulse count zero gives one pulse
    go_sleep();
    prox_en = 1; wait_en = 0; als_en = 0; wait_long = 0;
    pulse_count = 0; prox_time = 8'hFF;
    pon = 1;
    wait_prox(2);

    // Drain on pon low mid-conversion
    go_sleep();
    prox_en = 0; wait_en = 0; als_en = 1; als_time = 8'hF0;
    pon = 1;
    s0 = als_start_cnt;
    while (als_start_cnt == s0) @(negedge clk);
    s1 = als_hs_cnt;
    pon = 0;
    wait_neg(3);
    check(!asleep, "R9 no abort on pon low", asleep, 0);
    while (!asleep) @(negedge clk);
    check(als_hs_cnt == s1 + 1, "R9 conversion completed before sleep", als_hs_cnt - s1, 1);
    s0 = als_start_cnt;
    wait_neg(100);
    check(als_start_cnt == s0 && asleep, "R1 no activity after drain", als_start_cnt - s0, 0);

    // Idle start state with all enables clear
    prox_en = 0; wait_en = 0; als_en = 0;
    pon = 1;
    wait_neg(10);
    s0 = strobe_cnt;
    wait_neg(150);
    check(!asleep, "R10 awake with no enables", asleep, 0);
    check(strobe_cnt == s0, "R10 no strobes with no enables", strobe_cnt - s0, 0);
    als_en = 1; als_time = 8'hFF;
    wait_als(1);
    check(als_valid, "R3 enable picked up in start state", als_valid, 1);

    // Mid-cycle enable change applies on the next pass
    prox_en = 1; als_time = 8'hF0; pulse_count = 2;
    s0 = als_start_cnt;
    while (als_start_cnt < s0 + 2) @(negedge clk);
    s1 = als_hs_cnt;
    als_en = 0;
    wait_als(1);
    check(als_hs_cnt == s1 + 1, "R3 current ALS phase kept", als_hs_cnt - s1, 1);
    s0 = als_start_cnt;
    wait_prox(2);
    check(als_start_cnt == s0, "R3 ALS dropped on next pass", als_start_cnt - s0, 0);

    // Constrained random passes
    for (int it = 0; it < 12; it++) begin
      go_sleep();
      pulse_count = 8'($urandom_range(0, 4));
      prox_time = 8'hFF - 8'($urandom_range(0, 3));
      wait_time = 8'hFF - 8'($urandom_range(0, 3));
      als_time  = 8'hFF - 8'($urandom_range(0, 3));
      wait_long = 1'($urandom_range(0, 1));
      prox_en = 1'($urandom_range(0, 1));
      wait_en = 1'($urandom_range(0, 1));
      als_en = 1'($urandom_range(0, 1));
      if (!prox_en && !als_en) als_en = 1;
      pon = 1;
      tot = prox_hs_cnt + als_hs_cnt + 3;
      while (prox_hs_cnt + als_hs_cnt < tot) @(negedge clk);
    end
    go_sleep();
    check(asleep, "R9 random run ends asleep", asleep, 1);
    summary();
    $finish;
  end
endmodule